// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block controls the orderly shutdown and restart of a clock generator that has several outputs. One request pin asks for power-down. The request is asynchronous and active high. The block synchronizes the request and then qualifies it against a reference clock. After that it parks every gated output at a safe phase. It turns off the VCO and the crystal oscillator only after every output is parked. When the request goes away, the block powers the oscillators back up and waits for the PLL to report lock. It then lets each output resume cleanly.

Every signal is handled in one fast sampling clock domain. The source clocks (single-ended clocks, differential true/complement pairs, and the qualifying reference) arrive as free-running levels that are synchronous to that clock. Each output is gated by a run flag, and that flag changes only while its source is in the low phase, so no pulse is ever cut short. Each differential pair has a drive-mode bit that chooses how the pair rests while stopped: either the true pin is held high with the complement floating, or both pins float. The mode bits are captured when the request is recognized.

Top module: `pdseq_top`

## Requirements
- R1: A power-down request that stays high through fewer than two consecutive reference rising edges has no effect: `all_run` stays 1 and no output stops.
- R2: The request is passed through a synchronizer. It counts as recognized when the synchronized request is high at two consecutive rising edges of `ref_c`. Recognition starts the parking sequence.
- R3: While parking, a single-ended output goes low only at a falling edge of its own source and then stays low. Its rising and falling edges always coincide with the source's edges.
- R4: Each differential pair parks at a falling edge of its complement source. Every output is parked by the fourth reference period after recognition.
- R5: A parked pair whose captured mode bit is 0 drives the true pin high (`dt_oe`=1, `dt_clk`=1) and floats the complement (`dc_oe`=0).
- R6: A parked pair whose captured mode bit is 1 floats both pins (`dt_oe`=0, `dc_oe`=0).
- R7: `vco_en` and `xtal_en` go low only after every output is parked. While they are low, all single-ended outputs are 0 and all complement enables are 0.
- R8: Mode bits are captured when the request is recognized. Changing `drv_mode` while the outputs are parked does not change any parked pair.
- R9: After the synchronized request falls, both oscillator enables go high, and every parked pair drives its true pin high (`dt_oe`=1, `dt_clk`=1) before lock is reported.
- R10: After `pll_lock` is seen, each output resumes during the low phase of its source, with no extra edge. `all_run` goes to 1 once all outputs run, and then every output follows its source with all enables at 1.
- R11: If lock does not arrive within `LOCK_TMO` cycles of wake-up, `lock_err` goes to 1 and all outputs stay parked. A lock that arrives later does not release them.
- R12: A new recognized request clears the fault state. The block parks again and can then restart normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Asynchronous power-down request, active high |
| ref_c | input | 1 | Reference clock level used to qualify the request |
| se_src | input | NSE | Free-running single-ended source clocks |
| dt_src | input | ND | Differential true source clocks |
| dc_src | input | ND | Differential complement source clocks |
| drv_mode | input | ND | Park style per pair: 0 = true high, 1 = both floating |
| pll_lock | input | 1 | PLL lock indication |
| se_clk | output | NSE | Gated single-ended clocks |
| dt_clk | output | ND | Gated true pin values |
| dc_clk | output | ND | Gated complement pin values |
| dt_oe | output | ND | True pin output enables |
| dc_oe | output | ND | Complement pin output enables |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| all_run | output | 1 | All outputs running |
| lock_err | output | 1 | Lock timeout fault |

## Verification
The bench sweeps all four combinations of the two pair modes. It checks every parked pin pattern and then changes the mode inputs while the outputs are parked. A design that sampled the mode bits live would alter a pair that is already parked. A design that missed the wake-time lift would leave mode-1 pairs floating until lock.

A monitor watches every gated single-ended edge against its source. A gate that changed while its source was high would show an edge with no matching source edge, at either stop or restart. A request pulse shorter than two reference edges catches a qualifier that acts on a single sample.

A run that holds lock low checks that the fault keeps the outputs parked even when lock arrives late. That run then checks that a fresh request recovers the block.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [2:0] {
        PS_RUN   = 3'd0,
        PS_STOP  = 3'd1,
        PS_OFF   = 3'd2,
        PS_WAKE  = 3'd3,
        PS_START = 3'd4,
        PS_FAULT = 3'd5
    } seq_state_e;

    // Commands broadcast to every gate lane.
    typedef struct packed {
        logic park;    // stop at the next safe phase
        logic resume;  // restart at the next safe phase
        logic lift;    // drive parked true pins high regardless of mode
    } gate_cmd_t;

    function automatic int unsigned ctr_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic gate_cmd_t cmd_for(input seq_state_e s);
        gate_cmd_t c;
        c.park   = (s == PS_STOP);
        c.resume = (s == PS_START);
        c.lift   = (s == PS_WAKE) || (s == PS_START) || (s == PS_FAULT);
        return c;
    endfunction

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < int'(STAGES); k++) begin
                chain[k] <= chain[k-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pdseq_qualify.sv
module pdseq_qualify #(
    parameter int unsigned HITS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_clk,
    input  logic req_s,
    output logic recog
);
    localparam int unsigned HW = HITS - 1;

    logic          ref_q;
    logic [HW-1:0] hist;
    logic          ref_rise;

    assign ref_rise = ref_clk & ~ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            hist  <= '0;
        end else begin
            ref_q <= ref_clk;
            if (ref_rise) begin
                hist[0] <= req_s;
                for (int k = 1; k < int'(HW); k++) begin
                    hist[k] <= hist[k-1];
                end
            end
        end
    end

    // Current sample plus HW earlier samples, all high.
    assign recog = ref_rise & req_s & (&hist);
endmodule

// File: rtl/pdseq_se_gate.sv
module pdseq_se_gate
    import pdseq_pkg::*;
#(
    parameter int unsigned N = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  gate_cmd_t cmd,
    input  logic [N-1:0] src,
    output logic [N-1:0] gclk,
    output logic [N-1:0] live
);
    for (genvar i = 0; i < int'(N); i++) begin : g_lane
        logic run;

        // The run flag only changes while the source is low.
        always_ff @(posedge clk) begin
            if (rst) begin
                run <= 1'b1;
            end else if (!src[i]) begin
                if (cmd.park) begin
                    run <= 1'b0;
                end else if (cmd.resume) begin
                    run <= 1'b1;
                end
            end
        end

        assign gclk[i] = src[i] & run;
        assign live[i] = run;
    end
endmodule

// File: rtl/pdseq_diff_gate.sv
module pdseq_diff_gate
    import pdseq_pkg::*;
#(
    parameter int unsigned N = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  gate_cmd_t cmd,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] t_src,
    input  logic [N-1:0] c_src,
    output logic [N-1:0] t_out,
    output logic [N-1:0] c_out,
    output logic [N-1:0] t_oe,
    output logic [N-1:0] c_oe,
    output logic [N-1:0] live
);
    for (genvar i = 0; i < int'(N); i++) begin : g_pair
        logic run;

        // Park and resume on the complement's low phase (true is high then).
        always_ff @(posedge clk) begin
            if (rst) begin
                run <= 1'b1;
            end else if (!c_src[i]) begin
                if (cmd.park) begin
                    run <= 1'b0;
                end else if (cmd.resume) begin
                    run <= 1'b1;
                end
            end
        end

        assign t_out[i] = run ? t_src[i] : 1'b1;
        assign c_out[i] = run ? c_src[i] : 1'b0;
        assign t_oe[i]  = run | ~mode[i] | cmd.lift;
        assign c_oe[i]  = run;
        assign live[i]  = run;
    end
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
    import pdseq_pkg::*;
#(
    parameter int unsigned NSE         = 3,
    parameter int unsigned ND          = 2,
    parameter int unsigned LOCK_TMO    = 64,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_HITS   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pd_req,
    input  logic          ref_c,
    input  logic [NSE-1:0] se_src,
    input  logic [ND-1:0] dt_src,
    input  logic [ND-1:0] dc_src,
    input  logic [ND-1:0] drv_mode,
    input  logic          pll_lock,
    output logic [NSE-1:0] se_clk,
    output logic [ND-1:0] dt_clk,
    output logic [ND-1:0] dc_clk,
    output logic [ND-1:0] dt_oe,
    output logic [ND-1:0] dc_oe,
    output logic          vco_en,
    output logic          xtal_en,
    output logic          all_run,
    output logic          lock_err
);
    localparam int unsigned CW = ctr_bits(LOCK_TMO);
    localparam logic [CW-1:0] TMO_LAST = CW'(LOCK_TMO - 1);

    seq_state_e     state, nxt;
    logic [CW-1:0]  wait_cnt;
    logic [ND-1:0]  mode_q;
    logic           pd_s, recog;
    gate_cmd_t      cmd;
    logic [NSE-1:0] se_live;
    logic [ND-1:0]  d_live;
    logic           all_parked, all_live;
    logic           parking;

    pdseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pd_req), .q(pd_s)
    );

    pdseq_qualify #(.HITS(QUAL_HITS)) u_qual (
        .clk(clk), .rst(rst), .ref_clk(ref_c), .req_s(pd_s), .recog(recog)
    );

    assign cmd     = cmd_for(state);
    assign parking = cmd.park;

    pdseq_se_gate #(.N(NSE)) u_se (
        .clk(clk), .rst(rst), .cmd(cmd), .src(se_src),
        .gclk(se_clk), .live(se_live)
    );

    pdseq_diff_gate #(.N(ND)) u_diff (
        .clk(clk), .rst(rst), .cmd(cmd), .mode(mode_q),
        .t_src(dt_src), .c_src(dc_src),
        .t_out(dt_clk), .c_out(dc_clk), .t_oe(dt_oe), .c_oe(dc_oe),
        .live(d_live)
    );

    assign all_parked = ~(|se_live) & ~(|d_live);
    assign all_live   = (&se_live) & (&d_live);

    always_comb begin
        nxt = state;
        unique case (state)
            PS_RUN:   if (recog) nxt = PS_STOP;
            PS_STOP:  if (all_parked) nxt = PS_OFF;
            PS_OFF:   if (!pd_s) nxt = PS_WAKE;
            PS_WAKE: begin
                if (recog)                    nxt = PS_STOP;
                else if (pll_lock)            nxt = PS_START;
                else if (wait_cnt == TMO_LAST) nxt = PS_FAULT;
            end
            PS_START: begin
                if (recog)         nxt = PS_STOP;
                else if (all_live) nxt = PS_RUN;
            end
            PS_FAULT: if (recog) nxt = PS_STOP;
            default:  nxt = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_RUN;
            wait_cnt <= '0;
            mode_q   <= '0;
        end else begin
            state <= nxt;
            if (state == PS_WAKE) begin
                wait_cnt <= wait_cnt + 1'b1;
            end else begin
                wait_cnt <= '0;
            end
            if (nxt == PS_STOP && state != PS_STOP) begin
                mode_q <= drv_mode;
            end
        end
    end

    assign vco_en   = (state != PS_OFF);
    assign xtal_en  = (state != PS_OFF);
    assign all_run  = (state == PS_RUN);
    assign lock_err = (state == PS_FAULT);
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk #(
    parameter int unsigned NSE = 3,
    parameter int unsigned ND  = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           ref_c,
    input logic [NSE-1:0] se_src,
    input logic [NSE-1:0] se_clk,
    input logic [ND-1:0]  dt_clk,
    input logic [ND-1:0]  dt_oe,
    input logic [ND-1:0]  dc_oe,
    input logic           vco_en,
    input logic           xtal_en,
    input logic           all_run,
    input logic           lock_err,
    input logic           parking
);
    logic       ref_q;
    logic [2:0] ref_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= 1'b0;
            ref_cnt <= '0;
        end else begin
            ref_q <= ref_c;
            if (!parking) begin
                ref_cnt <= '0;
            end else if (ref_c && !ref_q && ref_cnt != 3'd7) begin
                ref_cnt <= ref_cnt + 3'd1;
            end
        end
    end

    // R4: parked before a fifth reference edge passes in the park phase
    a_r4_park_bound: assert property (@(posedge clk) disable iff (rst)
        (parking && ref_cnt >= 3'd5) |-> (se_clk == '0 && dc_oe == '0));

    // R7: oscillators off only with everything parked
    a_r7_osc_off_parked: assert property (@(posedge clk) disable iff (rst)
        !vco_en |-> (se_clk == '0 && dc_oe == '0 && !xtal_en));

    // R9: wake-up lifts every true pin high
    a_r9_wake_lift: assert property (@(posedge clk) disable iff (rst)
        $rose(vco_en) |-> (&dt_oe && &dt_clk));

    // R11: fault keeps outputs parked
    a_r11_fault_parked: assert property (@(posedge clk) disable iff (rst)
        lock_err |-> (se_clk == '0 && dc_oe == '0 && !all_run));

    // R10: running state has all pins driven
    a_r10_run_driven: assert property (@(posedge clk) disable iff (rst)
        all_run |-> (&dt_oe && &dc_oe && vco_en));

    for (genvar i = 0; i < int'(NSE); i++) begin : g_se
        // R3: gated falls only with the source
        a_r3_fall_with_src: assert property (@(posedge clk) disable iff (rst)
            $fell(se_clk[i]) |-> $fell(se_src[i]));
        // R10: gated rises only with the source
        a_r10_rise_with_src: assert property (@(posedge clk) disable iff (rst)
            $rose(se_clk[i]) |-> $rose(se_src[i]));
    end
endmodule

bind pdseq_top pdseq_chk #(.NSE(NSE), .ND(ND)) u_chk (
    .clk(clk), .rst(rst), .ref_c(ref_c), .se_src(se_src), .se_clk(se_clk),
    .dt_clk(dt_clk), .dt_oe(dt_oe), .dc_oe(dc_oe), .vco_en(vco_en),
    .xtal_en(xtal_en), .all_run(all_run), .lock_err(lock_err),
    .parking(parking)
);

// File: tb/tb_pdseq_top.sv
module tb_pdseq_top;
    localparam int NSE = 3;
    localparam int ND  = 2;
    localparam int TMO = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_req = 1'b0;
    logic ref_c = 1'b0;
    logic [NSE-1:0] se_src = '0;
    logic [ND-1:0] dt_src = '0;
    logic [ND-1:0] dc_src = '1;
    logic [ND-1:0] drv_mode = '0;
    logic pll_lock = 1'b1;
    logic [NSE-1:0] se_clk;
    logic [ND-1:0] dt_clk, dc_clk, dt_oe, dc_oe;
    logic vco_en, xtal_en, all_run, lock_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_act = 0;
    int glitches = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pdseq_top #(.NSE(NSE), .ND(ND), .LOCK_TMO(TMO)) dut (
        .clk(clk), .rst(rst), .pd_req(pd_req), .ref_c(ref_c),
        .se_src(se_src), .dt_src(dt_src), .dc_src(dc_src),
        .drv_mode(drv_mode), .pll_lock(pll_lock),
        .se_clk(se_clk), .dt_clk(dt_clk), .dc_clk(dc_clk),
        .dt_oe(dt_oe), .dc_oe(dc_oe), .vco_en(vco_en), .xtal_en(xtal_en),
        .all_run(all_run), .lock_err(lock_err)
    );

    // Source generator: ref period 6, single-ended 4/6/10, pairs 4/8.
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            #1;
            ph++;
            ref_c     = (ph % 6) < 3;
            se_src[0] = (ph % 4) < 2;
            se_src[1] = (ph % 6) >= 3;
            se_src[2] = (ph % 10) < 5;
            dt_src[0] = (ph % 4) >= 2;
            dt_src[1] = (ph % 8) < 4;
            dc_src    = ~dt_src;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    // Edge monitor: gated single-ended edges must match source edges.
    logic [NSE-1:0] se_clk_p = '0, se_src_p = '0;
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NSE; i++) begin
                if (se_clk[i] != se_clk_p[i] && se_src[i] == se_src_p[i]) glitches++;
            end
            if (|se_clk || |dc_oe) last_act = cyc;
        end
        se_clk_p = se_clk;
        se_src_p = se_src;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_vco(input logic val, output int took);
        took = 0;
        while (vco_en !== val && took < 300) begin
            @(negedge clk);
            took++;
        end
    endtask

    task automatic wait_run(output int took);
        took = 0;
        while (all_run !== 1'b1 && took < 300) begin
            @(negedge clk);
            took++;
        end
    endtask

    task automatic park_and_check(input logic [1:0] m);
        int took, c0;
        drv_mode = m;
        pd_req = 1'b1;
        c0 = cyc;
        wait_vco(1'b0, took);
        check("R2 request recognized, oscillators off", {31'd0, vco_en}, 32'd0);
        check("R7 parked before oscillator off", {31'd0, last_act < cyc}, 32'd1);
        check("R7 crystal enable low", {31'd0, xtal_en}, 32'd0);
        check("R4 park latency bound", {31'd0, (last_act - c0) <= 39}, 32'd1);
        check("R3 single-ended parked low", {29'd0, se_clk}, 32'd0);
        check("R5 R6 complement floating", {30'd0, dc_oe}, 32'd0);
        check("R5 R6 true enable per mode", {30'd0, dt_oe}, {30'd0, ~m});
        check("R5 mode-0 true high", {30'd0, dt_clk | m}, 32'd3);
        drv_mode = ~m;
        tick(10);
        check("R8 parked pair ignores mode change", {30'd0, dt_oe}, {30'd0, ~m});
    endtask

    task automatic wake_check();
        pll_lock = 1'b0;
        pd_req = 1'b0;
        tick(4);
        check("R9 oscillators back on", {30'd0, vco_en, xtal_en}, 32'd3);
        check("R9 true pins enabled before lock", {30'd0, dt_oe}, 32'd3);
        check("R9 true pins high before lock", {30'd0, dt_clk}, 32'd3);
        check("R9 not running before lock", {31'd0, all_run}, 32'd0);
    endtask

    task automatic restart_check();
        int took;
        pll_lock = 1'b1;
        wait_run(took);
        check("R10 all_run after lock", {31'd0, took < 30}, 32'd1);
        tick(12);
        check("R10 single-ended follow source", {29'd0, se_clk}, {29'd0, se_src});
        check("R10 true follow source", {30'd0, dt_clk}, {30'd0, dt_src});
        check("R10 complement follow source", {30'd0, dc_clk}, {30'd0, dc_src});
        check("R10 all enables on", {28'd0, dt_oe, dc_oe}, 32'hF);
    endtask

    initial begin
        int took;
        tick(5);
        rst = 1'b0;
        tick(3);
        check("R10 reset running", {31'd0, all_run}, 32'd1);
        check("R7 reset oscillators on", {30'd0, vco_en, xtal_en}, 32'd3);
        check("R11 reset no fault", {31'd0, lock_err}, 32'd0);
        check("R10 reset enables on", {28'd0, dt_oe, dc_oe}, 32'hF);

        // R1: short pulse right after a reference rise
        begin
            logic rp = ref_c;
            int dips = 0;
            took = 0;
            while (!(ref_c && !rp) && took < 20) begin
                rp = ref_c;
                @(negedge clk);
                took++;
            end
            pd_req = 1'b1;
            tick(3);
            pd_req = 1'b0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (all_run !== 1'b1) dips++;
            end
            check("R1 short request ignored", dips, 0);
        end

        for (int m = 0; m < 4; m++) begin
            park_and_check(m[1:0]);
            wake_check();
            restart_check();
        end

        // R11 and R12: lock never arrives, then recover
        park_and_check(2'b10);
        wake_check();
        tick(TMO + 10);
        check("R11 lock timeout flag", {31'd0, lock_err}, 32'd1);
        check("R11 outputs parked in fault", {27'd0, se_clk, dc_oe}, 32'd0);
        pll_lock = 1'b1;
        tick(10);
        check("R11 late lock does not release", {30'd0, lock_err, all_run}, 32'd2);
        pd_req = 1'b1;
        wait_vco(1'b0, took);
        check("R12 fault cleared by new request", {30'd0, lock_err, vco_en}, 32'd0);
        pd_req = 1'b0;
        wait_run(took);
        check("R12 restart after fault", {31'd0, all_run}, 32'd1);
        tick(12);
        check("R12 outputs follow source", {29'd0, se_clk}, {29'd0, se_src});

        check("R3 R10 no stray single-ended edge", glitches, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule